// File: doc/BRIEF.md
# JTAG Instruction Loader with Bypass Padding

This block is a small JTAG master that drives one scan chain holding several devices. It can perform two jobs. The first is a TMS-only chain reset, which leaves every TAP in Run-Test/Idle without any use of a TRST pin. The second loads an instruction into a single target device in the chain. Every other device in the chain receives all ones, which is the BYPASS opcode.

For an instruction load the block moves the chain from Idle into Shift-IR and serialises one combined stream. The stream starts with the ones for the devices between the target and TDO (the postfix count). Next comes the target instruction, least significant bit first. It ends with the ones for the devices between TDI and the target (the prefix count). TMS is raised on the final bit, and the block then passes through Update-IR and returns to Idle. TCK comes from the system clock divided by two. The caller starts a job with a one-cycle command, sees busy while the job runs, and gets a one-cycle done pulse when it completes.

Top module: `jtag_ir_loader`

## Requirements
- R1: While rst_n is low, and in the idle state afterwards, the outputs are tck=0, tms=0, tdi=0, busy=0 and done=0.
- R2: A reset job sends 9 TCK bits. TMS is 1 on the first 8 bits and 0 on the ninth. TDI is 0 on every bit.
- R3: An instruction job first sends 4 bits with TMS = 1, 1, 0, 0 and TDI = 0. These bits move the TAP from Idle through Select-DR and Select-IR to Capture-IR, and then into Shift-IR.
- R4: The shift phase lasts exactly ir_len + pre_bits + post_bits bits. TMS is 0 on every shift bit except the last one, where it is 1.
- R5: TDI during the shift phase is 1 for the first post_bits bits. The next ir_len bits carry ir_value starting at bit 0. The remaining pre_bits bits are 1.
- R6: After the shift phase the block sends two more bits: TMS=1 for Update-IR, then TMS=0 to return to Idle. TDI is 0 on both bits.
- R7: Each TCK bit lasts two clock cycles, with TCK low in the first cycle and high in the second. TMS and TDI change only when TCK goes low, so they are stable when TCK rises.
- R8: busy is 1 from the cycle after a command is accepted until the job ends. Commands that arrive while busy is 1 are ignored, and the output stream does not change.
- R9: done is 1 for exactly one cycle. That cycle follows the high half of the last bit of a job, and busy is already 0 in it.
- R10: If start_reset and start_ir are asserted in the same idle cycle, the reset job runs.
- R11: The prefix and postfix counts may each be 0 to 255, and ir_len may be 1 to 32. The corner values 0, 1, 32 and 255 give the stream lengths that R4 states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_reset | input | 1 | One-cycle command: TMS chain reset |
| start_ir | input | 1 | One-cycle command: load instruction |
| ir_value | input | MAX_IR | Target instruction, bit 0 shifted first |
| ir_len | input | LEN_W | Target IR length, 1 to MAX_IR |
| pre_bits | input | CNT_W | Bypass ones shifted after the instruction |
| post_bits | input | CNT_W | Bypass ones shifted before the instruction |
| tck | output | 1 | JTAG test clock (clk divided by two) |
| tms | output | 1 | JTAG mode select |
| tdi | output | 1 | JTAG serial data to the chain |
| busy | output | 1 | A job is running |
| done | output | 1 | One-cycle pulse when a job ends |

## Verification
The assertions assume that ir_len is at least 1 and that the command inputs are driven synchronously to clk. A zero length would make the shift phase empty, and then the last-bit rule on TMS would have no bit to apply to. The stimulus keeps to these limits. It uses lengths of 1, 4, 13 and 32, and prefix and postfix counts between 0 and 255. It also drives commands in the middle of running jobs, so that the ignore rule is exercised under the same assumptions.

// File: rtl/jtag_ir_loader.sv
module jtag_ir_loader #(
  parameter int MAX_IR = 32,
  parameter int CNT_W  = 8,
  localparam int LEN_W = $clog2(MAX_IR + 1),
  localparam int TOT_W = CNT_W + LEN_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_reset,
  input  logic              start_ir,
  input  logic [MAX_IR-1:0] ir_value,
  input  logic [LEN_W-1:0]  ir_len,
  input  logic [CNT_W-1:0]  pre_bits,
  input  logic [CNT_W-1:0]  post_bits,
  output logic              tck,
  output logic              tms,
  output logic              tdi,
  output logic              busy,
  output logic              done
);

  typedef enum logic [2:0] {S_IDLE, S_RST, S_NAV, S_SHIFT, S_TAIL} st_t;

  st_t               st;
  logic              ph;
  logic [TOT_W-1:0]  cnt;
  logic [MAX_IR-1:0] sreg;
  logic [LEN_W-1:0]  len_q;
  logic [CNT_W-1:0]  pre_q, post_q;
  logic              done_q;
  logic [TOT_W-1:0]  total, instr_lo, instr_hi;
  logic              in_instr, last;

  assign total    = TOT_W'(len_q) + TOT_W'(pre_q) + TOT_W'(post_q);
  assign instr_lo = TOT_W'(post_q);
  assign instr_hi = TOT_W'(post_q) + TOT_W'(len_q);
  assign in_instr = (cnt >= instr_lo) && (cnt < instr_hi);

  always_comb begin
    case (st)
      S_RST:   last = (cnt == TOT_W'(8));
      S_NAV:   last = (cnt == TOT_W'(3));
      S_SHIFT: last = (cnt == total - TOT_W'(1));
      S_TAIL:  last = (cnt == TOT_W'(1));
      default: last = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      ph     <= 1'b0;
      cnt    <= '0;
      sreg   <= '0;
      len_q  <= '0;
      pre_q  <= '0;
      post_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (st == S_IDLE) begin
        ph  <= 1'b0;
        cnt <= '0;
        if (start_reset) begin
          st <= S_RST;
        end else if (start_ir) begin
          st     <= S_NAV;
          sreg   <= ir_value;
          len_q  <= ir_len;
          pre_q  <= pre_bits;
          post_q <= post_bits;
        end
      end else begin
        ph <= ~ph;
        if (ph) begin
          if (st == S_SHIFT && in_instr) sreg <= sreg >> 1;
          if (last) begin
            cnt <= '0;
            case (st)
              S_NAV:   st <= S_SHIFT;
              S_SHIFT: st <= S_TAIL;
              default: begin st <= S_IDLE; done_q <= 1'b1; end
            endcase
          end else begin
            cnt <= cnt + TOT_W'(1);
          end
        end
      end
    end
  end

  always_comb begin
    case (st)
      S_RST:   tms = (cnt < TOT_W'(8));
      S_NAV:   tms = (cnt < TOT_W'(2));
      S_SHIFT: tms = last;
      S_TAIL:  tms = (cnt == TOT_W'(0));
      default: tms = 1'b0;
    endcase
  end

  assign tdi  = (st == S_SHIFT) ? (in_instr ? sreg[0] : 1'b1) : 1'b0;
  assign tck  = ph;
  assign busy = (st != S_IDLE);
  assign done = done_q;

  // R7
  tck_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (tck != $past(tck)));

  // R7
  data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tck) |-> ($stable(tms) && $stable(tdi)));

  // R4
  shift_tms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SHIFT && cnt < total - TOT_W'(1)) |-> !tms);

  // R8
  ignore_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (start_ir || start_reset)) |=> ($stable(len_q) && $stable(pre_q) && $stable(post_q)));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R9
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

endmodule

// File: tb/jtag_ir_loader_tb.sv
module jtag_ir_loader_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_IR = 32;
  localparam int CNT_W  = 8;
  localparam int LEN_W  = $clog2(MAX_IR + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_reset = 1'b0, start_ir = 1'b0;
  logic [MAX_IR-1:0] ir_value = '0;
  logic [LEN_W-1:0]  ir_len = '0;
  logic [CNT_W-1:0]  pre_bits = '0, post_bits = '0;
  logic tck, tms, tdi, busy, done;

  always #(CLK_PERIOD/2) clk = ~clk;

  jtag_ir_loader #(.MAX_IR(MAX_IR), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_reset(start_reset), .start_ir(start_ir),
    .ir_value(ir_value), .ir_len(ir_len), .pre_bits(pre_bits), .post_bits(post_bits),
    .tck(tck), .tms(tms), .tdi(tdi), .busy(busy), .done(done));

  typedef struct { bit tck; bit tms; bit tdi; string tag; } ent_t;
  ent_t q[$];
  bit   mdone = 1'b0;
  int   checks = 0, failures = 0;
  bit   finished = 1'b0;

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic void push_bit(bit m, bit d, string tag);
    ent_t e;
    e.tms = m; e.tdi = d; e.tag = tag;
    e.tck = 1'b0; q.push_back(e);
    e.tck = 1'b1; q.push_back(e);
  endfunction

  // Reference model: one queue entry per clock of the expected pin stream
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete();
      mdone = 1'b0;
    end else if (q.size() > 0) begin
      void'(q.pop_front());
      mdone = (q.size() == 0);
    end else begin
      mdone = 1'b0;
      if (start_reset) begin
        // R2 and R10
        for (int i = 0; i < 8; i++) push_bit(1'b1, 1'b0, "R2");
        push_bit(1'b0, 1'b0, "R2");
      end else if (start_ir) begin
        int tot;
        push_bit(1'b1, 1'b0, "R3"); push_bit(1'b1, 1'b0, "R3");
        push_bit(1'b0, 1'b0, "R3"); push_bit(1'b0, 1'b0, "R3");
        tot = int'(ir_len) + int'(pre_bits) + int'(post_bits);
        for (int k = 0; k < tot; k++) begin
          bit d;
          if (k < int'(post_bits)) d = 1'b1;
          else if (k < int'(post_bits) + int'(ir_len)) d = ir_value[k - int'(post_bits)];
          else d = 1'b1;
          push_bit(k == tot - 1, d, (k == tot - 1) ? "R4" : "R5");
        end
        push_bit(1'b1, 1'b0, "R6"); push_bit(1'b0, 1'b0, "R6");
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (q.size() > 0) begin
        chk("R7", "tck", tck, q[0].tck);
        chk(q[0].tag, "tms", tms, q[0].tms);
        chk(q[0].tag, "tdi", tdi, q[0].tdi);
        chk("R8", "busy", busy, 1);
        chk("R9", "done", done, 0);
      end else begin
        chk("R1", "tck", tck, 0);
        chk("R1", "tms", tms, 0);
        chk("R1", "tdi", tdi, 0);
        chk("R8", "busy", busy, 0);
        chk("R9", "done", done, mdone);
      end
    end
  end

  task automatic wait_idle();
    @(negedge clk);
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic cmd_ir(logic [MAX_IR-1:0] v, int len, int pre, int post);
    @(negedge clk);
    ir_value = v; ir_len = LEN_W'(len); pre_bits = CNT_W'(pre); post_bits = CNT_W'(post);
    start_ir = 1'b1;
    @(negedge clk);
    start_ir = 1'b0;
    wait_idle();
  endtask

  task automatic cmd_reset();
    @(negedge clk);
    start_reset = 1'b1;
    @(negedge clk);
    start_reset = 1'b0;
    wait_idle();
  endtask

  task automatic summary();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    chk("R1", "tck", tck, 0); chk("R1", "tms", tms, 0); chk("R1", "tdi", tdi, 0);
    chk("R1", "busy", busy, 0); chk("R1", "done", done, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    cmd_reset();                                  // R2
    cmd_ir(32'h8, 4, 2, 3);                       // R3 R4 R5 R6
    cmd_ir(32'hA5C3_0F96, 32, 0, 0);              // R11: no padding, full width
    cmd_ir(32'h0, 1, 0, 5);                       // R11: 1-bit IR
    cmd_ir(32'h1, 1, 7, 0);
    cmd_ir(32'h1ACE, 13, 255, 255);               // R11: maximum padding

    // R8: commands during a running job are ignored
    @(negedge clk);
    ir_value = 32'h3; ir_len = 4; pre_bits = 1; post_bits = 1; start_ir = 1'b1;
    @(negedge clk);
    start_ir = 1'b0;
    repeat (6) @(negedge clk);
    ir_value = 32'hFFFF_0000; ir_len = 32; pre_bits = 9; post_bits = 9;
    start_ir = 1'b1; start_reset = 1'b1;
    repeat (3) @(negedge clk);
    start_ir = 1'b0; start_reset = 1'b0;
    wait_idle();

    // R10: both commands together in idle, reset wins
    @(negedge clk);
    ir_value = 32'h5; ir_len = 4; pre_bits = 2; post_bits = 2;
    start_ir = 1'b1; start_reset = 1'b1;
    @(negedge clk);
    start_ir = 1'b0; start_reset = 1'b0;
    wait_idle();

    // back-to-back jobs
    cmd_ir(32'h2, 4, 0, 8);
    cmd_reset();
    repeat (4) @(negedge clk);
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
    end
  end
endmodule